// File: doc/BRIEF.md
# Recursive Binary-Tree Population Counter

This block reports how many bits of a parameter-width input word are set. It is purely combinational: the count follows the input with no clock, no register and no handshake, so it can sit inside any datapath stage that already holds its operand. Because no data is held, there is no valid/ready pair and no back-pressure. The result is valid whenever the input is stable.

The count is built as a tree that is elaborated from the width parameter. A word of length n is split into a lower part of floor(n/2) bits and an upper part holding the remaining bits, so an odd length gives the upper part the extra bit. Each part is counted by the same structure until a part is one bit wide, and that bit gives 1 when set and 0 when clear. The two partial counts are then added. Every adder is only as wide as the largest count its own subtree can produce, so a node covering `len` bits carries `$clog2(len+1)` bits.

Top module: `popc_tree`

## Requirements
- R1: For every input value, `ones` equals the number of bits of `din` that are 1.
- R2: `ones` is `$clog2(N+1)` bits wide. For N = 32 it is 6 bits and takes values from 0 to 32.
- R3: When `din` is all zeros, `ones` is 0, and every subtree reports zero exactly when its own bits are all clear.
- R4: When `din` is all ones, `ones` equals N with no wrap. No subtree count ever exceeds its own length.
- R5: A word with exactly one bit set yields 1 whatever the position of that bit, including the extra bit that an odd split places in the upper part.
- R6: Widths that are odd or are not a power of two, such as N = 33, give correct counts for all of R1, R3, R4 and R5.
- R7: The output settles within the same cycle as an input change, without any clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din  | input     | N     | Word whose set bits are counted |
| ones | output    | $clog2(N+1) | Number of set bits in `din` |

## Verification
Two effects meet in the same evaluation: the uneven split of an odd-length subvector, and the carry that the top adder must absorb when both halves are at their maximum. The bench drives words with all bits set at N = 33, where the 17-bit upper half and the 16-bit lower half both saturate, and it walks a single one across every position, including the extra upper bit. Each result is judged against a plain loop count computed in the bench, and no wrap or dropped bit is allowed.

// File: rtl/popc_pkg.sv
package popc_pkg;

  // Bits needed to hold any count from 0 to len inclusive.
  function automatic int cnt_width(input int len);
    return $clog2(len + 1);
  endfunction

endpackage

// File: rtl/popc_leaf.sv
// One-bit terminal of the counting tree: a set bit counts as 1.
module popc_leaf (
  input  logic       bit_in,
  output logic [0:0] count
);

  assign count = bit_in;

endmodule

// File: rtl/popc_join.sv
// Adds two partial counts into a result sized for the parent node.
module popc_join #(
  parameter int AW = 1,
  parameter int BW = 1,
  parameter int SW = 2
) (
  input  logic [AW-1:0] part_a,
  input  logic [BW-1:0] part_b,
  output logic [SW-1:0] sum
);

  assign sum = SW'(part_a) + SW'(part_b);

  // R4: the parent width must absorb the carry, so the sum never wraps
  always_comb begin
    a_r4_join_no_wrap: assert (sum >= SW'(part_a) && sum >= SW'(part_b))
      else $error("join sum wrapped");
  end

endmodule

// File: rtl/popc_node.sv
// Recursive node: splits its slice, counts both parts, adds the results.
module popc_node #(
  parameter  int LEN = 2,
  localparam int CW  = popc_pkg::cnt_width(LEN)
) (
  input  logic [LEN-1:0] bits,
  output logic [CW-1:0]  count
);

  generate
    if (LEN == 1) begin : g_leaf
      popc_leaf u_leaf (
        .bit_in (bits[0]),
        .count  (count)
      );
    end else begin : g_split
      // The lower part takes floor(LEN/2) bits; the upper takes the remainder.
      localparam int LO_LEN = LEN / 2;
      localparam int HI_LEN = LEN - LO_LEN;
      localparam int LO_W   = popc_pkg::cnt_width(LO_LEN);
      localparam int HI_W   = popc_pkg::cnt_width(HI_LEN);

      logic [LO_W-1:0] lo_cnt;
      logic [HI_W-1:0] hi_cnt;

      popc_node #(.LEN(LO_LEN)) u_lo (
        .bits  (bits[LO_LEN-1:0]),
        .count (lo_cnt)
      );

      popc_node #(.LEN(HI_LEN)) u_hi (
        .bits  (bits[LEN-1:LO_LEN]),
        .count (hi_cnt)
      );

      popc_join #(.AW(LO_W), .BW(HI_W), .SW(CW)) u_join (
        .part_a (lo_cnt),
        .part_b (hi_cnt),
        .sum    (count)
      );
    end
  endgenerate

  // R4: a subtree never reports more ones than it has bits
  // R3: a subtree reports zero exactly when its slice is clear
  always_comb begin
    a_r4_node_bound: assert (int'(count) <= LEN)
      else $error("node count above its length");
    a_r3_node_zero: assert ((bits == '0) == (count == '0))
      else $error("node zero flag mismatch");
  end

endmodule

// File: rtl/popc_tree.sv
// Top of the population counter.
module popc_tree #(
  parameter  int N  = 32,
  localparam int OW = popc_pkg::cnt_width(N)
) (
  input  logic [N-1:0]  din,
  output logic [OW-1:0] ones
);

  popc_node #(.LEN(N)) u_root (
    .bits  (din),
    .count (ones)
  );

  always_comb begin
    // R3: a clear word counts to zero
    if (din == '0) begin
      a_r3_all_clear: assert (ones == '0) else $error("clear word nonzero");
    end
    // R4: a full word counts to N without wrapping
    if (&din) begin
      a_r4_all_set: assert (ones == OW'(N)) else $error("full word miscounted");
    end
  end

endmodule

// File: tb/tb_popc_tree.sv
module tb_popc_tree;

  localparam int NA  = 32;
  localparam int NB  = 33;
  localparam int OWA = $clog2(NA + 1);
  localparam int OWB = $clog2(NB + 1);

  typedef struct {
    logic [NA-1:0] va;
    logic [NB-1:0] vb;
    int            ea;
    int            eb;
    string         tag;
  } item_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;  // 200 MHz

  logic [NA-1:0]  din_a = '0;
  logic [NB-1:0]  din_b = '0;
  logic [OWA-1:0] ones_a;
  logic [OWB-1:0] ones_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  item_t sb[$];

  popc_tree #(.N(NA)) dut     (.din(din_a), .ones(ones_a));
  popc_tree #(.N(NB)) dut_odd (.din(din_b), .ones(ones_b));

  function automatic int ref_a(input logic [NA-1:0] v);
    int c = 0;
    for (int i = 0; i < NA; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic int ref_b(input logic [NB-1:0] v);
    int c = 0;
    for (int i = 0; i < NB; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic judge(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver: applies a pair of words and queues their expected counts.
  task automatic drive(input logic [NA-1:0] va, input logic [NB-1:0] vb,
                       input string tag);
    item_t it;
    @(posedge clk);
    din_a = va;
    din_b = vb;
    it.va = va; it.vb = vb;
    it.ea = ref_a(va); it.eb = ref_b(vb);
    it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: compares at the falling edge, away from the driving edge.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      judge({it.tag, " w32"}, int'(ones_a), it.ea);
      judge({it.tag, " w33 (R6)"}, int'(ones_b), it.eb);
    end
  end

  initial begin
    // R2: output width and top-of-range value
    judge("R2 width32", $bits(ones_a), 6);
    judge("R2 width33", $bits(ones_b), 6);

    // R3: clear words, also the idle state
    #1;
    judge("R3 idle w32", int'(ones_a), 0);
    judge("R3 idle w33", int'(ones_b), 0);
    drive('0, '0, "R3");

    // R4: saturated halves at both widths
    drive('1, '1, "R4");

    // R5: walking one across every position, odd extra bit included
    for (int i = 0; i < NB; i++) begin
      drive(NA'(64'd1 << (i % NA)), NB'(64'd1 << i), "R5");
    end

    // R1: fixed patterns with known structure
    drive(32'h5555_5555, 33'h1_5555_5555, "R1");
    drive(32'hF0F0_0F0F, 33'h0_8000_0001, "R1");
    drive(32'h8000_0000, 33'h1_0000_0000, "R1");
    drive(32'hFFFF_0000, 33'h0_FFFF_FFFF, "R1");

    // R1: random words
    for (int k = 0; k < 300; k++) begin
      logic [NB-1:0] rb;
      rb = {$urandom() & 32'h1, $urandom()};
      drive($urandom(), rb, "R1");
    end

    // R7: no clock edge between the change and the sample
    @(negedge clk);
    wait (sb.size() == 0);
    #0.5;
    din_a = 32'h0000_00FF;
    din_b = 33'h1_0000_0007;
    #1;
    judge("R7 settle w32", int'(ones_a), 8);
    judge("R7 settle w33", int'(ones_b), 4);

    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule